// File: doc/BRIEF.md
# Flag-Carrying Integer ALU

This block is a 64-bit integer ALU whose result word is two bits wider than its data. Carry and signed overflow are written as bits 64 and 65 of the same word that holds the value. Flags therefore move through the one ordinary register write path, and no separate condition-code register exists. Multi-word arithmetic chains through a general register: add-with-carry and subtract-with-borrow read their carry-in from bit 64 of the second operand.

Each accepted operation gives one registered 66-bit result and a valid strobe one cycle later. The negative and zero conditions that a branch unit needs come from the data bits of that registered result. Zero looks at bits 0 to 63 only, so a set carry or overflow bit never hides a zero value.

Top module: `flagx_alu`

## Requirements
- R1: After reset `out_valid` is 0 and `result` is 0, so `cond_zero` is 1 and `cond_neg` is 0.
- R2: An operation accepted with `in_valid` high appears on `result`, and `out_valid` is high, exactly one clock later.
- R3: Opcode 0 (add) gives a[63:0]+b[63:0]. Bit 64 is the unsigned carry out. Bit 65 is set when both operands have the same sign and the sum's sign differs from it.
- R4: Opcode 1 (subtract) gives a + ~b + 1. Bit 64 is the carry out of that sum, so 1 means no borrow. Bit 65 is set when the operand signs differ and the result's sign differs from a's sign.
- R5: Opcode 2 (add with carry) adds b[64] as carry-in. Flags are formed as for add. Operand bits a[65:64] and b[65] have no effect.
- R6: Opcode 3 (subtract with borrow) computes a + ~b + b[64], so b[64]=0 borrows one more. Flags are formed as for subtract.
- R7: Opcodes 4, 5 and 6 (AND, OR, XOR of the data bits) and opcode 7 (move, giving b[63:0]) clear result bits 64 and 65.
- R8: `cond_neg` equals result bit 63.
- R9: `cond_zero` is 1 exactly when result bits 0 to 63 are all zero, whatever bits 64 and 65 hold.
- R10: While `in_valid` is low, `out_valid` is 0 one clock later and `result` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 3 | Operation code (0 add, 1 sub, 2 adc, 3 sbb, 4 and, 5 or, 6 xor, 7 move) |
| src_a | input | 66 | First operand with flag bits |
| src_b | input | 66 | Second operand; bit 64 is the chained carry |
| out_valid | output | 1 | Result register loaded last cycle |
| result | output | 66 | Data in [63:0], carry in [64], overflow in [65] |
| cond_neg | output | 1 | Negative condition of the result |
| cond_zero | output | 1 | Zero condition over data bits only |

## Verification
A wrong carry-in select or operand inversion shows up as a data or bit-64 mismatch on the very next result. Random multi-word chains make a swapped borrow polarity visible within a few operations. A flaw in the overflow term appears only near the signed limits, so directed cases sit there. A zero detector that takes in bit 64 is exposed by an add that wraps to zero with carry set. A result register that loads while idle shows up one cycle after the first idle input.

// File: rtl/flagx_pkg.sv
package flagx_pkg;
  localparam int DATA_W = 64;
  localparam int EXT_W  = DATA_W + 2;
  localparam int CY_BIT = DATA_W;
  localparam int OV_BIT = DATA_W + 1;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_ADC = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_MOV = 3'd7
  } alu_op_e;
endpackage

// File: rtl/flagx_adder.sv
module flagx_adder #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         invert_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff       = invert_b ? ~b : b;
    {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    // same-sign inputs to the adder with a differing sign out
    ovf         = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/flagx_logic.sv
module flagx_logic
  import flagx_pkg::*;
#(
  parameter int W = 64
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/flagx_cond.sv
module flagx_cond #(
  parameter int W = 64
) (
  input  logic [W+1:0] word,
  output logic         neg,
  output logic         zero
);
  assign neg  = word[W-1];
  assign zero = (word[W-1:0] == '0);
endmodule

// File: rtl/flagx_alu.sv
module flagx_alu
  import flagx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       op,
  input  logic [EXT_W-1:0] src_a,
  input  logic [EXT_W-1:0] src_b,
  output logic             out_valid,
  output logic [EXT_W-1:0] result,
  output logic             cond_neg,
  output logic             cond_zero
);
  alu_op_e           op_e;
  logic              is_arith;
  logic              inv_b;
  logic              carry_in;
  logic [DATA_W-1:0] add_sum;
  logic              add_cout;
  logic              add_ovf;
  logic [DATA_W-1:0] logic_y;
  logic [EXT_W-1:0]  next_word;

  assign op_e = alu_op_e'(op);

  always_comb begin
    is_arith = 1'b1;
    inv_b    = 1'b0;
    carry_in = 1'b0;
    unique case (op_e)
      OP_ADD: begin inv_b = 1'b0; carry_in = 1'b0; end
      OP_SUB: begin inv_b = 1'b1; carry_in = 1'b1; end
      OP_ADC: begin inv_b = 1'b0; carry_in = src_b[CY_BIT]; end
      OP_SBB: begin inv_b = 1'b1; carry_in = src_b[CY_BIT]; end
      default: is_arith = 1'b0;
    endcase
  end

  flagx_adder #(.W(DATA_W)) u_adder (
    .a        (src_a[DATA_W-1:0]),
    .b        (src_b[DATA_W-1:0]),
    .invert_b (inv_b),
    .cin      (carry_in),
    .sum      (add_sum),
    .cout     (add_cout),
    .ovf      (add_ovf)
  );

  flagx_logic #(.W(DATA_W)) u_logic (
    .op (op_e),
    .a  (src_a[DATA_W-1:0]),
    .b  (src_b[DATA_W-1:0]),
    .y  (logic_y)
  );

  assign next_word = is_arith ? {add_ovf, add_cout, add_sum}
                              : {2'b00, logic_y};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_word;
    end
  end

  flagx_cond #(.W(DATA_W)) u_cond (
    .word (result),
    .neg  (cond_neg),
    .zero (cond_zero)
  );

  // R2: valid strobe follows accepted operation by one cycle
  p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid) |=> out_valid);

  // R10: idle input leaves result untouched and strobe low
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!rst && !in_valid) |=> (!out_valid && $stable(result)));

  // R7: logical and move results carry no flags
  p_logic_flags_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid && op[2]) |=> (result[OV_BIT:CY_BIT] == 2'b00));

  // R7: move passes the second operand's data bits
  p_move_data_r7: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid && op == 3'd7) |=> (result[DATA_W-1:0] == $past(src_b[DATA_W-1:0])));

  // R9: zero condition ignores flag bits
  p_zero_ignores_flags_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && result[DATA_W-1:0] == '0) |-> cond_zero);

  p_inputs_known_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> !$isunknown({op, src_a, src_b}));
endmodule

// File: tb/flagx_alu_bench.sv
module flagx_alu_bench;
  localparam int W = 64;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  op;
  logic [65:0] src_a, src_b;
  logic        out_valid;
  logic [65:0] result;
  logic        cond_neg, cond_zero;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  flagx_alu u_flagx_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .result(result), .cond_neg(cond_neg), .cond_zero(cond_zero)
  );

  function automatic logic [65:0] model(input logic [2:0] o,
                                        input logic [65:0] a, input logic [65:0] b);
    logic [64:0] ua, ub, us;
    logic signed [66:0] sa, sb, ss;
    logic cin;
    logic ov;
    ua = {1'b0, a[63:0]};
    ub = {1'b0, b[63:0]};
    sa = {{3{a[63]}}, a[63:0]};
    sb = {{3{b[63]}}, b[63:0]};
    cin = b[64];
    case (o)
      3'd0: begin us = ua + ub;                 ss = sa + sb; end
      3'd1: begin us = ua + {1'b0, ~b[63:0]} + 65'd1; ss = sa - sb; end
      3'd2: begin us = ua + ub + {64'd0, cin};  ss = sa + sb + {66'd0, cin}; end
      3'd3: begin us = ua + {1'b0, ~b[63:0]} + {64'd0, cin};
                  ss = sa - sb - {66'd0, ~cin}; end
      3'd4: return {2'b00, a[63:0] & b[63:0]};
      3'd5: return {2'b00, a[63:0] | b[63:0]};
      3'd6: return {2'b00, a[63:0] ^ b[63:0]};
      default: return {2'b00, b[63:0]};
    endcase
    // signed result out of 64-bit range means overflow
    ov = (ss > 67'sh0_7FFF_FFFF_FFFF_FFFF) || (ss < -67'sh0_8000_0000_0000_0000);
    return {ov, us[64], us[63:0]};
  endfunction

  task automatic check(input string tag, input logic [65:0] got, input logic [65:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  string rtag [8] = '{"R3", "R4", "R5", "R6", "R7", "R7", "R7", "R7"};

  task automatic run_op(input logic [2:0] o, input logic [65:0] a, input logic [65:0] b);
    logic [65:0] e;
    e = model(o, a, b);
    in_valid = 1'b1; op = o; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 valid", {65'd0, out_valid}, 66'd1);
    check(rtag[o], result, e);
    check("R8 neg", {65'd0, cond_neg}, {65'd0, e[63]});
    check("R9 zero", {65'd0, cond_zero}, {65'd0, e[63:0] == 64'd0});
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [65:0] held;
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 1'b0; op = '0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 valid", {65'd0, out_valid}, 66'd0);
    check("R1 result", result, 66'd0);
    check("R1 zero", {65'd0, cond_zero}, 66'd1);
    check("R1 neg", {65'd0, cond_neg}, 66'd0);

    // R3 / R9: wrap to zero with carry set, zero still asserted
    run_op(3'd0, {2'b00, 64'hFFFF_FFFF_FFFF_FFFF}, 66'd1);
    check("R9 wrap", {65'd0, cond_zero}, 66'd1);
    check("R3 carry", {65'd0, result[64]}, 66'd1);
    // R3 positive overflow
    run_op(3'd0, {2'b00, 64'h7FFF_FFFF_FFFF_FFFF}, 66'd1);
    check("R3 ovf", {65'd0, result[65]}, 66'd1);
    // R4 borrow and equal operands
    run_op(3'd1, 66'd0, 66'd1);
    check("R4 borrow", {65'd0, result[64]}, 66'd0);
    run_op(3'd1, 66'h1234, 66'h1234);
    check("R4 noborrow", {65'd0, result[64]}, 66'd1);
    run_op(3'd1, {2'b00, 64'h8000_0000_0000_0000}, 66'd1);
    check("R4 ovf", {65'd0, result[65]}, 66'd1);
    // R5 carry-in from b[64], a flags and b[65] ignored
    run_op(3'd2, {2'b11, 64'd5}, {2'b11, 64'd7});
    check("R5 cin", result, 66'd13);
    run_op(3'd2, {2'b11, 64'd5}, {2'b10, 64'd7});
    check("R5 nocin", result, 66'd12);
    // R6 borrow-in polarity
    run_op(3'd3, 66'd10, {2'b00, 64'd3});
    check("R6 extra borrow", result[63:0], 66'd6);
    run_op(3'd3, 66'd10, {2'b01, 64'd3});
    check("R6 no borrow", result[63:0], 66'd7);
    // R7 logic with flag bits present in inputs
    run_op(3'd5, {2'b11, 64'h0F}, {2'b11, 64'hF0});
    run_op(3'd7, {2'b11, 64'h0}, {2'b11, 64'h8000_0000_0000_0000});

    // R10 idle hold
    held = result;
    in_valid = 1'b0; op = 3'd0; src_a = 66'h3_1111; src_b = 66'h2_2222;
    @(negedge clk);
    check("R10 valid", {65'd0, out_valid}, 66'd0);
    check("R10 hold", result, held);

    // random mix, including 256-bit chained adds
    for (int i = 0; i < 300; i++) begin
      logic [65:0] a, b;
      a = {$urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom};
      if (i % 4 == 0) begin a[63:0] = {a[63], 63'h7FFF_FFFF_FFFF_FFFF}; end
      run_op(3'($urandom_range(0, 7)), a, b);
    end
    for (int k = 0; k < 20; k++) begin
      logic [65:0] carry;
      carry = 66'd0;
      for (int w = 0; w < 4; w++) begin
        logic [65:0] a, b;
        a = {2'b00, $urandom, $urandom};
        b = {carry[65:64] & 2'b01, $urandom, $urandom};
        run_op((k % 2 == 0) ? 3'd2 : 3'd3, a, b);
        carry = result;
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule